// File: doc/BRIEF.md
# Flash Write-Unlock Command Controller

This block sits between a narrow register bus and an embedded flash array and lets erase and program commands reach the array only after a two-byte unlock key has been written. Software writes the key bytes to a key register. It then chooses the target memory space through a segment register, loads an address and two data words, and launches either a program, by writing data word 1, or an erase, by writing the command register. Each accepted command produces one request on a valid/ready channel toward the array and sets a busy flag. The flag clears when the array returns a done pulse for that operation.

Unlocking covers exactly one command attempt. A command that is accepted and a command that is refused both close the unlock, so every new operation needs the full key again. Writes to unrelated registers between the two key bytes leave the partial unlock in place. The address is word-aligned in program space and checked against the size of the selected space. An address outside that space is refused without any request reaching the array.

The request channel follows valid/ready rules. Once `req_valid` rises, it stays high and the payload stays unchanged until a cycle in which `req_ready` is high. The array may therefore apply back-pressure for any number of cycles. No second request can queue behind the first, because the busy flag set at acceptance blocks every new command.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After a reset, writing 0xFA to the key register (select 0) and then 0xF5 opens the unlock. Status bit 2 reads 1 while the unlock is open. A command can be accepted only while it is open.
- R2: While the first key byte is pending, writes to the segment, address, data and status registers, and command-register writes with bit 0 clear, do not cancel it.
- R3: Any key write other than 0xF5 after 0xFA, including a second 0xFA, returns the unlock to locked. A key write of anything other than 0xFA while the unlock is open also locks it.
- R4: A write to data word 1 (select 4) while the unlock is open launches a program command (`req_op`=1). The same write while locked launches nothing.
- R5: A command attempted while either busy flag is set is refused, and no new request is issued.
- R6: In program space the two lowest address bits are forced to zero. The programmed 32-bit word is {data word 1, data word 0}.
- R7: In data-flash space one byte is programmed, taken from data word 0 bits 7:0. The request data is zero-extended, and the upper byte of data word 0 has no effect on it.
- R8: A segment register (select 1) value of 0 selects program space (`req_space`=0). Any other value selects data flash (`req_space`=1).
- R9: The erase-busy flag (status bit 0) and the program-busy flag (status bit 1) are set when a command of that kind is accepted. Each clears only on its done pulse. Writes to the status register (select 6) are ignored.
- R10: A command whose aligned address is not below the size of the selected space (program 0x8000 bytes, data 0x0800 bytes by default) is refused, and no request is issued.
- R11: While `req_valid` is high and `req_ready` is low, `req_valid` and the whole payload hold. `req_valid` falls after the cycle in which `req_ready` is high.
- R12: Any command attempt while the unlock is open, whether accepted or refused, locks the unlock.
- R13: A write to the command register (select 5) with bit 0 set launches an erase (`req_op`=0, data 0). A write with bit 0 clear is not a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 3 | Register select: 0 key, 1 segment, 2 address, 3 data 0, 4 data 1, 5 command, 6 status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register (key and command read 0) |
| req_valid | output | 1 | Request to the flash array is pending |
| req_ready | input | 1 | Array accepts the pending request |
| req_op | output | 1 | 1 program, 0 erase |
| req_space | output | 1 | 0 program memory, 1 data flash |
| req_addr | output | 16 | Target byte address |
| req_data | output | 32 | Program data |
| done_erase | input | 1 | Pulse: erase finished |
| done_prog | input | 1 | Pulse: program finished |

## Verification
The bench goes after the corners of the key sequence. It places unrelated writes between the two key bytes, where a design that resets on any write would refuse valid unlocks. It writes a wrong byte or a repeated 0xFA after the first byte, where a design without the cancel would unlock on a later 0xF5. It tries a second command while the first is still busy and its request is held by back-pressure, where a faulty design would overwrite the payload or fail to lock the unlock. It also sends an unaligned program-space address, a byte with a dirty upper half in data flash, and addresses just past each space's end, which expose missing masking, wrong data packing and missing range checks.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  typedef enum logic [1:0] {UL_IDLE, UL_HALF, UL_OPEN} ul_state_t;
  typedef enum logic {SP_PROG = 1'b0, SP_DATA = 1'b1} space_t;
  typedef enum logic {OP_ERASE = 1'b0, OP_PROG = 1'b1} op_t;
  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_KEY  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_SEG  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_ADR  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_D0   = 3'd3;
  localparam logic [SEL_W-1:0] SEL_D1   = 3'd4;
  localparam logic [SEL_W-1:0] SEL_CMD  = 3'd5;
  localparam logic [SEL_W-1:0] SEL_STAT = 3'd6;
endpackage

// File: rtl/fcc_unlock.sv
module fcc_unlock
  import fcc_pkg::*;
#(
  parameter logic [7:0] KEY_A = 8'hFA,
  parameter logic [7:0] KEY_B = 8'hF5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_byte,
  input  logic       cmd_try,
  output logic       open
);
  ul_state_t st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= UL_IDLE;
    end else if (cmd_try && st == UL_OPEN) begin
      st <= UL_IDLE;
    end else if (key_wr) begin
      case (st)
        UL_HALF: st <= (key_byte == KEY_B) ? UL_OPEN : UL_IDLE;
        default: st <= (key_byte == KEY_A) ? UL_HALF : UL_IDLE;
      endcase
    end
  end

  assign open = (st == UL_OPEN);

  AST_OTHER_WRITES_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !key_wr && !cmd_try |=> $stable(st)); // R2
  AST_WRONG_BYTE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr && st == UL_HALF && key_byte != KEY_B |=> st == UL_IDLE); // R3
  AST_ATTEMPT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_try && open |=> !open); // R12
endmodule

// File: rtl/fcc_decode.sv
module fcc_decode
  import fcc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int PROG_BYTES = 32768,
  parameter int DATA_BYTES = 2048,
  parameter int ALIGN_BITS = 2
) (
  input  logic [7:0]        seg,
  input  logic [ADDR_W-1:0] raw_addr,
  output space_t            space,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              in_range
);
  localparam logic [ADDR_W:0] PROG_LIM = (ADDR_W+1)'(PROG_BYTES);
  localparam logic [ADDR_W:0] DATA_LIM = (ADDR_W+1)'(DATA_BYTES);

  always_comb begin
    space = (seg == 8'h00) ? SP_PROG : SP_DATA;
    if (space == SP_PROG) begin
      eff_addr = {raw_addr[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
      in_range = ({1'b0, eff_addr} < PROG_LIM);
    end else begin
      eff_addr = raw_addr;
      in_range = ({1'b0, eff_addr} < DATA_LIM);
    end
  end
endmodule

// File: rtl/fcc_issue.sv
module fcc_issue
  import fcc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  op_t               op_in,
  input  space_t            space_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [WORD_W-1:0] data_in,
  input  logic              ready,
  input  logic              done_erase,
  input  logic              done_prog,
  output logic              valid,
  output op_t               op_q,
  output space_t            space_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [WORD_W-1:0] data_q,
  output logic              erase_busy,
  output logic              prog_busy
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      op_q    <= OP_ERASE;
      space_q <= SP_PROG;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (accept) begin
      valid   <= 1'b1;
      op_q    <= op_in;
      space_q <= space_in;
      addr_q  <= addr_in;
      data_q  <= data_in;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      erase_busy <= 1'b0;
      prog_busy  <= 1'b0;
    end else begin
      if (accept && op_in == OP_ERASE) erase_busy <= 1'b1;
      else if (done_erase)             erase_busy <= 1'b0;
      if (accept && op_in == OP_PROG)  prog_busy <= 1'b1;
      else if (done_prog)              prog_busy <= 1'b0;
    end
  end

  AST_HOLD_UNDER_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(addr_q) && $stable(data_q) && $stable(op_q)); // R11
  AST_BUSY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({erase_busy, prog_busy})); // R5
  AST_VALID_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (erase_busy || prog_busy)); // R9
  AST_NO_ACCEPT_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_busy || prog_busy) |-> !accept); // R5
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcc_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          BUS_W      = 16,
  parameter int          PROG_BYTES = 32768,
  parameter int          DATA_BYTES = 2048,
  parameter logic [7:0]  KEY_A      = 8'hFA,
  parameter logic [7:0]  KEY_B      = 8'hF5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [2:0]        bus_sel,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_op,
  output logic              req_space,
  output logic [ADDR_W-1:0] req_addr,
  output logic [2*BUS_W-1:0] req_data,
  input  logic              done_erase,
  input  logic              done_prog
);
  localparam int WORD_W = 2 * BUS_W;

  logic [7:0]        seg_q;
  logic [ADDR_W-1:0] adr_q;
  logic [BUS_W-1:0]  d0_q, d1_q;
  logic              open, in_range, accept, prog_try, erase_try, cmd_try;
  logic              erase_busy, prog_busy;
  space_t            space, space_q;
  op_t               op_new, op_q;
  logic [ADDR_W-1:0] eff_addr;
  logic [WORD_W-1:0] data_new;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= '0;
      adr_q <= '0;
      d0_q  <= '0;
      d1_q  <= '0;
    end else if (bus_wr) begin
      case (bus_sel)
        SEL_SEG: seg_q <= bus_wdata[7:0];
        SEL_ADR: adr_q <= ADDR_W'(bus_wdata);
        SEL_D0:  d0_q  <= bus_wdata;
        SEL_D1:  d1_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  assign prog_try  = bus_wr && bus_sel == SEL_D1;
  assign erase_try = bus_wr && bus_sel == SEL_CMD && bus_wdata[0];
  assign cmd_try   = prog_try || erase_try;
  assign op_new    = prog_try ? OP_PROG : OP_ERASE;
  assign accept    = cmd_try && open && !erase_busy && !prog_busy && in_range;

  always_comb begin
    if (!prog_try)            data_new = '0;
    else if (space == SP_PROG) data_new = {bus_wdata, d0_q};
    else                       data_new = WORD_W'(d0_q[7:0]);
  end

  fcc_unlock #(.KEY_A(KEY_A), .KEY_B(KEY_B)) u_unlock (
    .clk(clk), .rst_n(rst_n),
    .key_wr(bus_wr && bus_sel == SEL_KEY), .key_byte(bus_wdata[7:0]),
    .cmd_try(cmd_try), .open(open));

  fcc_decode #(.ADDR_W(ADDR_W), .PROG_BYTES(PROG_BYTES), .DATA_BYTES(DATA_BYTES)) u_decode (
    .seg(seg_q), .raw_addr(adr_q), .space(space), .eff_addr(eff_addr), .in_range(in_range));

  fcc_issue #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_issue (
    .clk(clk), .rst_n(rst_n), .accept(accept), .op_in(op_new), .space_in(space),
    .addr_in(eff_addr), .data_in(data_new), .ready(req_ready),
    .done_erase(done_erase), .done_prog(done_prog),
    .valid(req_valid), .op_q(op_q), .space_q(space_q), .addr_q(req_addr), .data_q(req_data),
    .erase_busy(erase_busy), .prog_busy(prog_busy));

  assign req_op    = (op_q == OP_PROG);
  assign req_space = (space_q == SP_DATA);

  always_comb begin
    case (bus_sel)
      SEL_SEG:  bus_rdata = BUS_W'(seg_q);
      SEL_ADR:  bus_rdata = BUS_W'(adr_q);
      SEL_D0:   bus_rdata = d0_q;
      SEL_D1:   bus_rdata = d1_q;
      SEL_STAT: bus_rdata = BUS_W'({open, prog_busy, erase_busy});
      default:  bus_rdata = '0;
    endcase
  end

  AST_ISSUE_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> $past(open)); // R1
  AST_PROG_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_space |-> req_addr[1:0] == 2'b00); // R6
  AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ({1'b0, req_addr} < (req_space ? (ADDR_W+1)'(DATA_BYTES) : (ADDR_W+1)'(PROG_BYTES)))); // R10
  AST_BYTE_ZERO_EXTENDED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_space && req_op |-> req_data[WORD_W-1:8] == '0); // R7
endmodule

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_sel = 3'd6;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        req_valid, req_op, req_space;
  logic        req_ready = 1'b1;
  logic [15:0] req_addr;
  logic [31:0] req_data;
  logic        done_erase = 1'b0, done_prog = 1'b0;

  int checks = 0;
  int errors = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  flash_cmd_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_space(req_space), .req_addr(req_addr), .req_data(req_data),
    .done_erase(done_erase), .done_prog(done_prog));

  // behavioural reference model
  int          m_ul;       // 0 locked, 1 first byte seen, 2 open
  bit          m_eb, m_pb, m_v, m_op, m_sp;
  logic [7:0]  m_seg;
  logic [15:0] m_adr, m_d0, m_d1, m_addr;
  logic [31:0] m_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ul = 0; m_eb = 0; m_pb = 0; m_v = 0; m_op = 0; m_sp = 0;
      m_seg = 0; m_adr = 0; m_d0 = 0; m_d1 = 0; m_addr = 0; m_data = 0;
    end else begin
      bit tp, te, sp, inr, acc;
      logic [15:0] ea;
      tp = bus_wr && bus_sel == 3'd4;
      te = bus_wr && bus_sel == 3'd5 && bus_wdata[0];
      sp = (m_seg != 0);
      ea = sp ? m_adr : (m_adr & 16'hFFFC);
      inr = sp ? (ea < 16'h0800) : (ea < 16'h8000);
      acc = (tp || te) && m_ul == 2 && !m_eb && !m_pb && inr;
      if (acc) begin
        m_v = 1; m_op = tp; m_sp = sp; m_addr = ea;
        m_data = !tp ? 32'h0 : (sp ? {24'h0, m_d0[7:0]} : {bus_wdata, m_d0});
      end else if (m_v && req_ready) m_v = 0;
      m_eb = (acc && te) ? 1 : (m_eb && !done_erase);
      m_pb = (acc && tp) ? 1 : (m_pb && !done_prog);
      if ((tp || te) && m_ul == 2) m_ul = 0;
      else if (bus_wr && bus_sel == 3'd0) begin
        if (m_ul == 1) m_ul = (bus_wdata[7:0] == 8'hF5) ? 2 : 0;
        else           m_ul = (bus_wdata[7:0] == 8'hFA) ? 1 : 0;
      end
      if (bus_wr) case (bus_sel)
        3'd1: m_seg = bus_wdata[7:0];
        3'd2: m_adr = bus_wdata;
        3'd3: m_d0 = bus_wdata;
        3'd4: m_d1 = bus_wdata;
        default: ;
      endcase
    end
  end

  function automatic logic [15:0] m_read(input logic [2:0] s);
    case (s)
      3'd1: return {8'h0, m_seg};
      3'd2: return m_adr;
      3'd3: return m_d0;
      3'd4: return m_d1;
      3'd6: return {13'h0, (m_ul == 2), m_pb, m_eb};
      default: return 16'h0;
    endcase
  endfunction

  // every-cycle comparison against the model (R11 covers hold behaviour)
  always @(negedge clk) begin
    if (rst_n && !ended) begin
      checks++;
      if (req_valid !== m_v || bus_rdata !== m_read(bus_sel) ||
          (m_v && (req_op !== m_op || req_space !== m_sp || req_addr !== m_addr || req_data !== m_data))) begin
        errors++;
        $display("FAIL R11 model compare: valid=%0b op=%0b sp=%0b addr=%h data=%h rd=%h exp valid=%0b op=%0b sp=%0b addr=%h data=%h rd=%h",
          req_valid, req_op, req_space, req_addr, req_data, bus_rdata,
          m_v, m_op, m_sp, m_addr, m_data, m_read(bus_sel));
      end
    end
  end

  task automatic expect_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [15:0] d);
    bus_wr = 1'b1; bus_sel = s; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_sel = 3'd6; bus_wdata = '0;
    #2;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  task automatic pulse(input bit erase);
    if (erase) done_erase = 1'b1; else done_prog = 1'b1;
    @(posedge clk); #1;
    done_erase = 1'b0; done_prog = 1'b0;
    #2;
  endtask

  task automatic unlock();
    wr(3'd0, 16'h00FA);
    wr(3'd0, 16'h00F5);
  endtask

  task automatic finish_run();
    ended = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #2;
    expect_eq("R9 reset status", bus_rdata, 32'h0);
    expect_eq("R9 reset valid", req_valid, 0);

    unlock();
    expect_eq("R1 open after key", bus_rdata, 32'h4);
    wr(3'd0, 16'h0000);
    expect_eq("R3 wrong byte while open locks", bus_rdata, 32'h0);

    wr(3'd0, 16'h00FA);
    wr(3'd1, 16'h0000);
    wr(3'd2, 16'h0103);
    wr(3'd3, 16'hBEEF);
    wr(3'd6, 16'hFFFF);
    wr(3'd5, 16'h0000);
    wr(3'd0, 16'h00F5);
    expect_eq("R2 unrelated writes keep pending key", bus_rdata, 32'h4);

    req_ready = 1'b0;
    wr(3'd4, 16'h1234);
    expect_eq("R4 program launched", req_valid, 1);
    expect_eq("R4 op program", req_op, 1);
    expect_eq("R8 space program", req_space, 0);
    expect_eq("R6 aligned address", req_addr, 32'h0100);
    expect_eq("R6 word data", req_data, 32'h1234BEEF);
    expect_eq("R9 program busy, R12 unlock closed", bus_rdata, 32'h2);
    step(3);
    expect_eq("R11 held under backpressure", req_valid, 1);
    wr(3'd6, 16'hFFFF);
    expect_eq("R9 status read-only", bus_rdata, 32'h2);
    unlock();
    wr(3'd4, 16'h5555);
    expect_eq("R5 busy refuses, payload kept", req_data, 32'h1234BEEF);
    expect_eq("R12 refused attempt locks", bus_rdata, 32'h2);
    req_ready = 1'b1;
    step(1);
    expect_eq("R11 valid drops after ready", req_valid, 0);
    expect_eq("R9 busy until done", bus_rdata, 32'h2);
    pulse(0);
    expect_eq("R9 done clears busy", bus_rdata, 32'h0);

    wr(3'd4, 16'h7777);
    step(1);
    expect_eq("R4 locked write launches nothing", req_valid, 0);

    wr(3'd0, 16'h00FA);
    wr(3'd0, 16'h0012);
    wr(3'd0, 16'h00F5);
    expect_eq("R3 wrong byte cancels", bus_rdata, 32'h0);
    wr(3'd0, 16'h00FA);
    wr(3'd0, 16'h00FA);
    wr(3'd0, 16'h00F5);
    expect_eq("R3 repeated first byte cancels", bus_rdata, 32'h0);

    wr(3'd1, 16'h0001);
    wr(3'd2, 16'h0013);
    wr(3'd3, 16'hAB5C);
    unlock();
    wr(3'd4, 16'h9999);
    expect_eq("R8 space data", req_space, 1);
    expect_eq("R7 byte address unmasked", req_addr, 32'h0013);
    expect_eq("R7 byte data", req_data, 32'h0000005C);
    pulse(0);

    wr(3'd2, 16'h0900);
    unlock();
    wr(3'd4, 16'h0001);
    expect_eq("R10 data out of range", req_valid, 0);
    expect_eq("R10 no busy, R12 locked", bus_rdata, 32'h0);
    wr(3'd1, 16'h0000);
    wr(3'd2, 16'h8002);
    unlock();
    wr(3'd4, 16'h0001);
    expect_eq("R10 program out of range", req_valid, 0);

    wr(3'd1, 16'h0001);
    wr(3'd2, 16'h0040);
    unlock();
    wr(3'd5, 16'h0000);
    expect_eq("R13 bit0 clear is no command", bus_rdata, 32'h4);
    wr(3'd5, 16'h0001);
    expect_eq("R13 erase op", req_op, 0);
    expect_eq("R13 erase address", req_addr, 32'h0040);
    expect_eq("R13 erase busy", bus_rdata, 32'h1);
    pulse(1);
    expect_eq("R9 erase done clears", bus_rdata, 32'h0);

    step(2);
    finish_run();
  end
endmodule